// File: doc/BRIEF.md
# Single-channel up-counting PWM timer

This block produces one pulse-width-modulated output from an up-counter driven through a programmable clock prescaler. Software programs it through a small synchronous register port: a control word, a prescaler divisor, a period limit and a compare threshold. The counter runs from zero up to the period limit, then wraps back to zero. Each wrap is an update event, which raises a sticky update flag.

The period and compare values can each be buffered. When buffering is on, a written value waits in a holding register and becomes active only at the next update event, so a running waveform never sees a half-changed setting. Software can also force an update event at any time, which restarts the count.

The output path has four stages:
- a waveform mode selects the reference signal;
- a polarity bit may invert it;
- a channel enable gates it;
- a master enable either passes the result or replaces it with a programmable idle level.

Top module: `pwm_chan_timer`

## Requirements
- R1: Register addresses are 0 control, 1 prescaler, 2 period, 3 compare, 4 counter (read only), 5 status, 6 event. Control bits are: bit0 count enable, bit1 period buffering, bit2 compare buffering, bits6:4 mode, bit7 polarity, bit8 channel enable, bit9 master enable, bit10 idle level. After reset every register reads 0, `pwm_o` is 0 and `upd_flag_o` is 0.
- R2: The counter advances once every prescaler+1 clocks, so consecutive wraps are (period+1)*(prescaler+1) clocks apart.
- R3: The counter counts from 0 up to the period value and then wraps to 0. The wrap is an update event and sets the update flag (status bit0).
- R4: Mode code 110 makes the reference active while counter < compare; code 111 gives the inverse. Code 100 forces it inactive and code 101 forces it active; all other codes give inactive. With code 110, a compare value of 0 keeps the reference inactive, and a compare value above the period keeps it active for the whole period.
- R5: With compare buffering on, a compare write changes only the holding value (which the compare address reads back). The active threshold takes that value at the next update event. With buffering off, a write takes effect at once.
- R6: With period buffering on, a period write takes effect only at the next update event. With buffering off, it takes effect at once.
- R7: Writing 1 to event bit0 clears the counter and the prescaler count, loads both holding values into the active registers and sets the update flag. The event address always reads 0.
- R8: Writing 0 to status bit0 clears the update flag. Writing 1 leaves it unchanged.
- R9: With master enable set, `pwm_o` equals reference XOR polarity while channel enable is 1, and is 0 while channel enable is 0.
- R10: With master enable clear, `pwm_o` equals the idle-level bit whatever the counter does.
- R11: With count enable clear, the counter and prescaler count hold, and the output keeps following the current comparison.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data for `reg_addr`, combinational |
| pwm_o | output | 1 | PWM output pin |
| upd_flag_o | output | 1 | Sticky update flag |

## Verification
The bench builds the block with an 8-bit counter, an 8-bit prescaler and a 16-bit register port. These values keep full periods to a few clocks, so duty can be counted by sampling every cycle of a complete period, and wrap spacing can be timed exactly. Small periods also make the compare-above-period and compare-zero extremes, and the first-period-versus-second-period difference of a buffered period change, cheap to reach.

// File: rtl/pwm_chan_timer.sv
module pwm_chan_timer #(
  parameter int CNT_W = 16,
  parameter int PSC_W = 16,
  parameter int DW    = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [2:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          pwm_o,
  output logic          upd_flag_o
);
  localparam logic [2:0] A_CTRL = 3'd0, A_PSC = 3'd1, A_PER = 3'd2, A_CMP = 3'd3,
                         A_CNT  = 3'd4, A_STAT = 3'd5, A_EVT = 3'd6;
  localparam logic [2:0] M_LO = 3'b100, M_HI = 3'b101, M_PWM1 = 3'b110, M_PWM2 = 3'b111;
  localparam int CTRL_W = 11;

  logic [CTRL_W-1:0] ctrl;
  logic [PSC_W-1:0]  psc_q, psc_cnt;
  logic [CNT_W-1:0]  per_pre, per_act, cmp_pre, cmp_act, cnt;
  logic              flag;

  logic       cnt_en, per_buf, cmp_buf, pol, chan_en, master_en, idle_lvl;
  logic [2:0] mode;
  assign cnt_en    = ctrl[0];
  assign per_buf   = ctrl[1];
  assign cmp_buf   = ctrl[2];
  assign mode      = ctrl[6:4];
  assign pol       = ctrl[7];
  assign chan_en   = ctrl[8];
  assign master_en = ctrl[9];
  assign idle_lvl  = ctrl[10];

  logic sw_upd, tick, wrap, upd_evt;
  assign sw_upd  = reg_we && reg_addr == A_EVT && reg_wdata[0];
  assign tick    = cnt_en && psc_cnt >= psc_q;
  assign wrap    = tick && cnt >= per_act;
  assign upd_evt = sw_upd || wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl  <= '0;
      psc_q <= '0;
    end else if (reg_we) begin
      if (reg_addr == A_CTRL) ctrl  <= reg_wdata[CTRL_W-1:0];
      if (reg_addr == A_PSC)  psc_q <= reg_wdata[PSC_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc_cnt <= '0;
      cnt     <= '0;
    end else if (sw_upd) begin
      psc_cnt <= '0;
      cnt     <= '0;
    end else if (cnt_en) begin
      psc_cnt <= tick ? '0 : psc_cnt + 1'b1;
      if (tick) cnt <= wrap ? '0 : cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_pre <= '0;
      per_act <= '0;
      cmp_pre <= '0;
      cmp_act <= '0;
    end else begin
      if (upd_evt) begin
        per_act <= per_pre;
        cmp_act <= cmp_pre;
      end
      if (reg_we && reg_addr == A_PER) begin
        per_pre <= reg_wdata[CNT_W-1:0];
        if (!per_buf) per_act <= reg_wdata[CNT_W-1:0];
      end
      if (reg_we && reg_addr == A_CMP) begin
        cmp_pre <= reg_wdata[CNT_W-1:0];
        if (!cmp_buf) cmp_act <= reg_wdata[CNT_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                          flag <= 1'b0;
    else if (upd_evt)                                    flag <= 1'b1;
    else if (reg_we && reg_addr == A_STAT && !reg_wdata[0]) flag <= 1'b0;
  end
  assign upd_flag_o = flag;

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = DW'(ctrl);
      A_PSC:   reg_rdata = DW'(psc_q);
      A_PER:   reg_rdata = DW'(per_pre);
      A_CMP:   reg_rdata = DW'(cmp_pre);
      A_CNT:   reg_rdata = DW'(cnt);
      A_STAT:  reg_rdata = DW'(flag);
      default: reg_rdata = '0;
    endcase
  end

  logic below, ref_lvl;
  assign below = cnt < cmp_act;
  always_comb begin
    case (mode)
      M_PWM1:  ref_lvl = below;
      M_PWM2:  ref_lvl = !below;
      M_HI:    ref_lvl = 1'b1;
      M_LO:    ref_lvl = 1'b0;
      default: ref_lvl = 1'b0;
    endcase
  end

  assign pwm_o = !master_en ? idle_lvl : (chan_en && (ref_lvl ^ pol));
endmodule

// File: rtl/pwm_chan_timer_chk.sv
module pwm_chan_timer_chk #(
  parameter int CNT_W = 16,
  parameter int DW    = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_we,
  input logic [2:0]       reg_addr,
  input logic [DW-1:0]    reg_wdata,
  input logic             pwm_o,
  input logic             upd_flag_o,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] cmp_act,
  input logic             cmp_buf,
  input logic             cnt_en,
  input logic             upd_evt,
  input logic [2:0]       mode,
  input logic             pol,
  input logic             chan_en,
  input logic             master_en
);
  logic ug_wr;
  assign ug_wr = reg_we && reg_addr == 3'd6 && reg_wdata[0];

  // R7
  ug_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ug_wr |=> (cnt == '0 && upd_flag_o));

  // R8
  flag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 3'd5 && reg_wdata[0] && upd_flag_o) |=> upd_flag_o);

  // R11
  hold_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !ug_wr) |=> $stable(cnt));

  // R3
  step_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cnt) |-> (cnt == '0 || cnt == $past(cnt) + 1'b1));

  // R5
  cmp_shadow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_buf && !upd_evt) |=> $stable(cmp_act));

  // R4
  cmp_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_act == '0 && mode == 3'b110 && chan_en && master_en && !pol) |-> !pwm_o);
endmodule

bind pwm_chan_timer pwm_chan_timer_chk #(.CNT_W(CNT_W), .DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .pwm_o(pwm_o), .upd_flag_o(upd_flag_o),
  .cnt(cnt), .cmp_act(cmp_act), .cmp_buf(cmp_buf), .cnt_en(cnt_en),
  .upd_evt(upd_evt), .mode(mode), .pol(pol), .chan_en(chan_en),
  .master_en(master_en)
);

// File: tb/pwm_chan_timer_tb_top.sv
`timescale 1ns/1ps
module pwm_chan_timer_tb_top;
  localparam int CNT_W = 8, PSC_W = 8, DW = 16;

  logic clk = 1'b0, rst_n = 1'b0, reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0, reg_rdata;
  logic pwm_o, upd_flag_o;
  int total = 0, fails = 0, cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pwm_chan_timer #(.CNT_W(CNT_W), .PSC_W(PSC_W), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwm_o(pwm_o),
    .upd_flag_o(upd_flag_o));

  // {period[27:20], compare[19:12], polarity[11], mode[10:8], expected high count[7:0]}
  localparam logic [27:0] VEC [10] = '{
    {8'd9,  8'd4,  1'b0, 3'b110, 8'd4},
    {8'd9,  8'd0,  1'b0, 3'b110, 8'd0},
    {8'd9,  8'd12, 1'b0, 3'b110, 8'd10},
    {8'd9,  8'd4,  1'b1, 3'b110, 8'd6},
    {8'd9,  8'd4,  1'b0, 3'b111, 8'd6},
    {8'd7,  8'd8,  1'b0, 3'b110, 8'd8},
    {8'd15, 8'd1,  1'b0, 3'b110, 8'd1},
    {8'd9,  8'd3,  1'b0, 3'b101, 8'd10},
    {8'd9,  8'd3,  1'b0, 3'b100, 8'd0},
    {8'd9,  8'd3,  1'b0, 3'b010, 8'd0}
  };

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input int d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = DW'(d);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    @(negedge clk);
    reg_addr = a;
    #0.5 v = int'(reg_rdata);
  endtask

  task automatic count_high(input int n, output int hi);
    hi = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      hi += int'(pwm_o);
    end
  endtask

  task automatic wait_flag(output int t);
    while (!upd_flag_o) @(negedge clk);
    t = cyc;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  int v, hi, t0, t1, t2;
  initial begin
    repeat (3) @(negedge clk);
    check("R1 pwm after reset", int'(pwm_o), 0);
    check("R1 flag after reset", int'(upd_flag_o), 0);
    rst_n = 1'b1;
    for (int a = 0; a < 7; a++) begin
      rd(3'(a), v);
      check("R1 register reset value", v, 0);
    end
    wr(0, 16'h0301);
    rd(0, v);
    check("R1 control readback", v, 16'h0301);

    // R4 R9: duty cycle over one full period for each vector
    foreach (VEC[k]) begin
      wr(1, 0);
      wr(2, VEC[k][27:20]);
      wr(3, VEC[k][19:12]);
      wr(0, 1 | (VEC[k][10:8] << 4) | (VEC[k][11] << 7) | (1 << 8) | (1 << 9));
      wr(6, 1);
      count_high(VEC[k][27:20] + 1, hi);
      check("R4 R9 duty vector", hi, VEC[k][7:0]);
    end

    // R2 R3: wrap spacing with prescaler 3, period 4
    wr(1, 3); wr(2, 4); wr(3, 2);
    wr(0, 1 | (3'b110 << 4) | (3 << 8));
    wr(6, 1);
    wait_flag(t1);
    wr(5, 0);
    wait_flag(t2);
    check("R2 wrap spacing", t2 - t1, 20);
    wr(5, 0);
    wait_flag(t1);
    check("R3 next wrap spacing", t1 - t2, 20);

    // R8: write 1 keeps the flag, write 0 clears it
    wr(0, 3 << 8);
    wr(6, 1);
    wr(5, 1);
    rd(5, v);
    check("R8 write one keeps flag", v, 1);
    wr(5, 0);
    check("R8 write zero clears flag", int'(upd_flag_o), 0);

    // R11: counter holds while stopped
    wr(1, 0); wr(2, 200);
    wr(0, 1 | (3 << 8));
    repeat (7) @(negedge clk);
    wr(0, 3 << 8);
    rd(4, t0);
    repeat (6) @(negedge clk);
    rd(4, t1);
    check("R11 counter holds", t1, t0);
    check("R11 counter nonzero before restart", int'(t0 != 0), 1);

    // R7: software update clears the counter, event reads 0
    wr(6, 1);
    rd(4, v);
    check("R7 counter cleared", v, 0);
    rd(6, v);
    check("R7 event reads zero", v, 0);

    // R5: buffered compare applies only at update event
    wr(2, 9); wr(3, 5);
    wr(0, (3'b110 << 4) | (3 << 8));
    wr(6, 1);
    check("R11 output follows comparison while stopped", int'(pwm_o), 1);
    wr(0, 4 | (3'b110 << 4) | (3 << 8));
    wr(3, 0);
    check("R5 buffered compare not yet active", int'(pwm_o), 1);
    rd(3, v);
    check("R5 holding value readback", v, 0);
    wr(6, 1);
    check("R5 buffered compare active after update", int'(pwm_o), 0);
    wr(0, (3'b110 << 4) | (3 << 8));
    wr(3, 5);
    check("R5 unbuffered compare immediate", int'(pwm_o), 1);

    // R6: buffered period, first wrap uses old value
    wr(0, 2 | (3 << 8));
    wr(2, 9);
    wr(6, 1);
    wr(2, 3);
    wr(5, 0);
    wr(0, 3 | (3 << 8));
    t0 = cyc;
    wait_flag(t1);
    check("R6 first period uses old value", t1 - t0, 10);
    wr(5, 0);
    wait_flag(t2);
    check("R6 next period uses new value", t2 - t1, 4);

    // R10: master disabled forces idle level
    wr(0, 1); wr(2, 9); wr(3, 5); wr(6, 1);
    wr(0, 1 | (3'b110 << 4) | (1 << 8) | (1 << 10));
    count_high(10, hi);
    check("R10 idle level one", hi, 10);
    wr(0, 1 | (3'b110 << 4) | (1 << 8));
    count_high(10, hi);
    check("R10 idle level zero", hi, 0);

    // R9: channel disabled gives low output
    wr(0, 1 | (3'b101 << 4) | (1 << 9));
    count_high(10, hi);
    check("R9 channel disabled", hi, 0);

    finish_run();
  end
endmodule